// File: doc/BRIEF.md
# Dual Byte-FIFO DMA Data Path

This block sits between a 16-bit host bus and a byte-wide instrument bus engine. Two 8-bit FIFOs, an upper one (A) and a lower one (B), each `DEPTH` entries deep, together form one 16-bit host word. The host reaches them with active-low read and write strobes. An access is selected either by the decoded FIFO address (`fifo_cs`) or by the DMA acknowledge (`dack_n`), which needs no address. Active-low upper and lower byte enables choose the lanes. The instrument side is modelled as a plain byte push/pop port that picks one FIFO with `ib_sel_a`.

`xfer_to_bus` sets the direction. When it is high, the host writes and the instrument side pops. When it is low, the instrument side pushes and the host reads. A byte counter, loaded by `cnt_load`, counts down on DMA accesses. It gates the DMA request and raises a sticky completion interrupt once the last byte has been handed over. In burst mode the oldest word is always on the read bus, and each read strobe removes one word.

Top module: `dma_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty and `drq`, `done_irq`, `err_flag` and `xfer_left` are 0. `host_rdata` is 0, and `fifo_ready` is 1 while `xfer_to_bus` is 1.
- R2: An access completes on the rising edge of its strobe. When both enables are low (`ube_n`=0, `lbe_n`=0), a write places `host_wdata[15:8]` into FIFO A and `host_wdata[7:0]` into FIFO B, and a read returns {A head, B head}.
- R3: With only the upper enable active (`ube_n`=0, `lbe_n`=1), FIFO B is reached on bits 15:8. With only the lower enable active, FIFO B is reached on bits 7:0. The unused lane reads as 0.
- R4: With `dack_n` low, a strobe accesses the FIFOs even when `fifo_cs` is low.
- R5: When `burst_mode` is 1, `host_rdata` shows {A head, B head} at all times, without a strobe or select. Each rising edge of `rd_n` removes one word.
- R6: When `burst_mode` is 0, `host_rdata` is 0 unless `rd_n` is low and the access is selected.
- R7: `fifo_ready` is 1 when neither FIFO is full (host writing), or when neither FIFO is empty (host reading).
- R8: `xfer_left` loads from `cnt_value` on `cnt_load`. Each DMA access lowers it by 2 for a two-lane access, or by 1 for a one-lane access, and it saturates at 0.
- R9: `drq` is 1 only when `dma_en` is 1, `xfer_left` is nonzero, and the FIFOs can serve the next access. In wide mode that means both FIFOs; otherwise FIFO B only. The FIFOs must not be full when writing and not empty when reading.
- R10: After a nonzero load, `done_irq` sets once the count is 0. When writing, the FIFOs must also be drained to the bus. `done_irq` stays set until `stat_clr`.
- R11: A push into a full FIFO or a pop from an empty one leaves the FIFO unchanged and sets the sticky `err_flag`, which `stat_clr` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_to_bus | input | 1 | 1: host writes, instrument pops; 0: instrument pushes, host reads |
| burst_mode | input | 1 | Head word always driven; rd_n rises pop a word |
| fifo_cs | input | 1 | Decoded FIFO address select |
| dack_n | input | 1 | DMA acknowledge, active low, selects FIFOs |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| ube_n | input | 1 | Upper byte enable, active low |
| lbe_n | input | 1 | Lower byte enable, active low |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word |
| fifo_ready | output | 1 | FIFOs can take a word access |
| dma_en | input | 1 | DMA request enable |
| dma_wide | input | 1 | DMA uses both lanes |
| cnt_load | input | 1 | Load the byte counter |
| cnt_value | input | 32 | Byte count to load |
| drq | output | 1 | DMA request |
| xfer_left | output | 32 | Bytes remaining |
| done_irq | output | 1 | Sticky transfer-complete interrupt |
| err_flag | output | 1 | Sticky overflow/underflow flag |
| stat_clr | input | 1 | Clears done_irq and err_flag |
| ib_sel_a | input | 1 | Instrument side picks FIFO A (1) or B (0) |
| ib_push | input | 1 | Instrument byte push |
| ib_wdata | input | 8 | Instrument push byte |
| ib_pop | input | 1 | Instrument byte pop |
| ib_rdata | output | 8 | Head of selected FIFO |
| ib_avail | output | 1 | Selected FIFO not empty |
| ib_space | output | 1 | Selected FIFO not full |

## Verification
If a read or write pointer is wrong, the wrong byte shows up at `ib_rdata` or `host_rdata` on the first pop after the error. If the lane routing is wrong, bytes land in the other FIFO, so the other instrument-side FIFO reports data one cycle after the strobe ends. A counter fault shows at once on `xfer_left`, and one cycle later as a `drq` that stays up or drops too early. A fault in the drain or arming logic shows as `done_irq` rising before the FIFOs are empty, or never rising.

// File: rtl/dfp_pkg.sv
// Shared types for the dual byte-FIFO data path.
// Assumes byte enables are active low and sampled with the strobe.
package dfp_pkg;
    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2,
        LANE_BOTH = 2'd3
    } lane_e;

    // Map active-low enables to a lane selection.
    function automatic lane_e lane_of(input logic ube_n, input logic lbe_n);
        case ({ube_n, lbe_n})
            2'b00:   return LANE_BOTH;
            2'b01:   return LANE_HI;
            2'b10:   return LANE_LO;
            default: return LANE_NONE;
        endcase
    endfunction
endpackage

// File: rtl/byte_fifo.sv
// Synchronous byte FIFO with head look-ahead.
// A push when full or a pop when empty is rejected and reported by a pulse.
// Assumes a simultaneous push and pop are both allowed when not full/empty.
module byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         rej
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rej     = (push && full) || (pop && empty);
    assign head    = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> cnt == $past(cnt)); // R11
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> cnt == $past(cnt)); // R11
endmodule

// File: rtl/host_strobe.sv
// Host strobe front end: captures select, lanes and data while a strobe
// is low and reports a one-cycle event on its rising edge.
// Assumes rd_n and wr_n are synchronous to clk and never low together.
module host_strobe
    import dfp_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          fifo_cs,
    input  logic          dack_n,
    input  logic          ube_n,
    input  logic          lbe_n,
    input  logic [HW-1:0] wdata,
    output logic          rd_ev,
    output logic          wr_ev,
    output logic          ev_sel,
    output logic          ev_dma,
    output lane_e         ev_lane,
    output logic [HW-1:0] ev_wdata
);
    logic rd_q, wr_q;

    assign rd_ev = !rd_q && rd_n;
    assign wr_ev = !wr_q && wr_n;

    // Strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    // Access attributes held from the low phase of a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_sel   <= 1'b0;
            ev_dma   <= 1'b0;
            ev_lane  <= LANE_NONE;
            ev_wdata <= '0;
        end else if (!rd_n || !wr_n) begin
            ev_sel   <= fifo_cs || !dack_n;
            ev_dma   <= !dack_n;
            ev_lane  <= lane_of(ube_n, lbe_n);
            ev_wdata <= wdata;
        end
    end
endmodule

// File: rtl/xfer_ctrl.sv
// Byte counter and completion interrupt for DMA transfers.
// Counts down by 1 or 2 with saturation; the interrupt arms on a nonzero
// load and fires once the count is zero and the data has drained.
module xfer_ctrl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    input  logic             dec,
    input  logic             dec2,
    input  logic             drained,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic armed;

    // Counter load and saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= value;
        end else if (dec) begin
            if (dec2) cnt <= (cnt >= CNT_W'(2)) ? cnt - CNT_W'(2) : '0;
            else      cnt <= (cnt != '0) ? cnt - CNT_W'(1) : '0;
        end
    end

    // Arming and sticky completion interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (irq_clr) irq <= 1'b0;
            if (load) begin
                armed <= (value != '0);
            end else if (armed && cnt == '0 && drained) begin
                armed <= 1'b0;
                irq   <= 1'b1;
            end
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == '0 && !load |=> cnt == '0); // R8
    AST_CNT_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt <= $past(cnt)); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq); // R10
endmodule

// File: rtl/dma_fifo_pair.sv
// Top of the dual byte-FIFO data path: lane routing, burst presentation,
// direction gating, DMA request, counter and sticky status flags.
// Assumes the host and instrument side never push the same FIFO at once;
// direction picks which side may push and which may pop.
module dma_fifo_pair
    import dfp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_to_bus,
    input  logic             burst_mode,
    input  logic             fifo_cs,
    input  logic             dack_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             ube_n,
    input  logic             lbe_n,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    output logic             fifo_ready,
    input  logic             dma_en,
    input  logic             dma_wide,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    output logic             drq,
    output logic [CNT_W-1:0] xfer_left,
    output logic             done_irq,
    output logic             err_flag,
    input  logic             stat_clr,
    input  logic             ib_sel_a,
    input  logic             ib_push,
    input  logic [7:0]       ib_wdata,
    input  logic             ib_pop,
    output logic [7:0]       ib_rdata,
    output logic             ib_avail,
    output logic             ib_space
);
    localparam int NF = 2; // index 1 = FIFO A (upper), 0 = FIFO B (lower)

    logic        rd_ev, wr_ev, ev_sel, ev_dma;
    lane_e       ev_lane, cur_lane;
    logic [15:0] ev_wdata;
    logic [7:0]  f_head [NF];
    logic [7:0]  f_wdata [NF];
    logic [NF-1:0] f_push, f_pop, f_full, f_empty, f_rej;
    logic [NF-1:0] h_push, h_pop, i_push, i_pop;
    logic        h_wr_ok, h_rd_ok, dma_dec, dma_dec2;

    host_strobe #(.HW(16)) u_strobe (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
        .fifo_cs(fifo_cs), .dack_n(dack_n), .ube_n(ube_n), .lbe_n(lbe_n),
        .wdata(host_wdata), .rd_ev(rd_ev), .wr_ev(wr_ev), .ev_sel(ev_sel),
        .ev_dma(ev_dma), .ev_lane(ev_lane), .ev_wdata(ev_wdata)
    );

    // Host-side push/pop requests per FIFO, gated by direction.
    always_comb begin
        h_wr_ok = wr_ev && ev_sel && xfer_to_bus;
        h_rd_ok = rd_ev && (ev_sel || burst_mode) && !xfer_to_bus;
        h_push  = {h_wr_ok && ev_lane == LANE_BOTH, h_wr_ok && ev_lane != LANE_NONE};
        h_pop   = {h_rd_ok && (burst_mode || ev_lane == LANE_BOTH),
                   h_rd_ok && (burst_mode || ev_lane != LANE_NONE)};
        i_push  = {ib_push && ib_sel_a, ib_push && !ib_sel_a} & {NF{!xfer_to_bus}};
        i_pop   = {ib_pop && ib_sel_a, ib_pop && !ib_sel_a} & {NF{xfer_to_bus}};
        f_wdata[1] = xfer_to_bus ? ev_wdata[15:8] : ib_wdata;
        f_wdata[0] = !xfer_to_bus ? ib_wdata :
                     (ev_lane == LANE_HI) ? ev_wdata[15:8] : ev_wdata[7:0];
        f_push  = xfer_to_bus ? h_push : i_push;
        f_pop   = xfer_to_bus ? i_pop : h_pop;
    end

    for (genvar g = 0; g < NF; g++) begin : g_fifo
        byte_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(f_push[g]), .wdata(f_wdata[g]),
            .pop(f_pop[g]), .head(f_head[g]), .full(f_full[g]),
            .empty(f_empty[g]), .rej(f_rej[g])
        );
    end

    // Host read bus: burst presentation or selected lane routing.
    always_comb begin
        cur_lane   = lane_of(ube_n, lbe_n);
        host_rdata = '0;
        if (burst_mode) begin
            host_rdata = {f_head[1], f_head[0]};
        end else if (!rd_n && (fifo_cs || !dack_n)) begin
            case (cur_lane)
                LANE_BOTH: host_rdata = {f_head[1], f_head[0]};
                LANE_HI:   host_rdata = {f_head[0], 8'h00};
                LANE_LO:   host_rdata = {8'h00, f_head[0]};
                default:   host_rdata = '0;
            endcase
        end
    end

    // Readiness, DMA request and instrument-side status.
    always_comb begin
        fifo_ready = xfer_to_bus ? !(f_full[1] || f_full[0]) : !(f_empty[1] || f_empty[0]);
        drq = dma_en && (xfer_left != '0) &&
              (dma_wide ? fifo_ready : (xfer_to_bus ? !f_full[0] : !f_empty[0]));
        ib_rdata = ib_sel_a ? f_head[1] : f_head[0];
        ib_avail = ib_sel_a ? !f_empty[1] : !f_empty[0];
        ib_space = ib_sel_a ? !f_full[1] : !f_full[0];
        dma_dec  = ev_dma && (h_wr_ok || h_rd_ok);
        dma_dec2 = burst_mode || ev_lane == LANE_BOTH;
    end

    xfer_ctrl #(.CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .value(cnt_value),
        .dec(dma_dec), .dec2(dma_dec2),
        .drained(!xfer_to_bus || (f_empty[1] && f_empty[0])),
        .irq_clr(stat_clr), .cnt(xfer_left), .irq(done_irq)
    );

    // Sticky overflow/underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           err_flag <= 1'b0;
        else if (|f_rej)      err_flag <= 1'b1;
        else if (stat_clr)    err_flag <= 1'b0;
    end

    AST_ERR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (|f_rej) |=> err_flag); // R11
    AST_IRQ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> (!xfer_to_bus || $past(f_empty[1] && f_empty[0]))); // R10
endmodule

// File: tb/dma_fifo_pair_tb.sv
module dma_fifo_pair_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        xfer_to_bus = 1'b1, burst_mode = 1'b0, fifo_cs = 1'b0, dack_n = 1'b1;
    logic        rd_n = 1'b1, wr_n = 1'b1, ube_n = 1'b1, lbe_n = 1'b1;
    logic [15:0] host_wdata = '0, host_rdata;
    logic        fifo_ready, dma_en = 1'b0, dma_wide = 1'b0, cnt_load = 1'b0;
    logic [31:0] cnt_value = '0, xfer_left;
    logic        drq, done_irq, err_flag, stat_clr = 1'b0;
    logic        ib_sel_a = 1'b0, ib_push = 1'b0, ib_pop = 1'b0;
    logic [7:0]  ib_wdata = '0, ib_rdata;
    logic        ib_avail, ib_space;
    int          n_chk = 0, n_fail = 0;
    logic [15:0] rd_word;

    always #2 clk = ~clk;

    dma_fifo_pair u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Host write: lanes {ube_n,lbe_n}, select by cs or dack.
    task automatic hwrite(input logic [1:0] en_n, input logic cs, input logic dk, input logic [15:0] d);
        @(negedge clk);
        {ube_n, lbe_n} = en_n; fifo_cs = cs; dack_n = !dk; host_wdata = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; fifo_cs = 1'b0; dack_n = 1'b1; {ube_n, lbe_n} = 2'b11;
        @(negedge clk);
    endtask

    // Host read: returns the word seen while the strobe is low.
    task automatic hread(input logic [1:0] en_n, input logic cs, input logic dk, output logic [15:0] d);
        @(negedge clk);
        {ube_n, lbe_n} = en_n; fifo_cs = cs; dack_n = !dk; rd_n = 1'b0;
        #1 d = host_rdata;
        @(negedge clk);
        rd_n = 1'b1; fifo_cs = 1'b0; dack_n = 1'b1; {ube_n, lbe_n} = 2'b11;
        @(negedge clk);
    endtask

    task automatic ibpush(input logic sel_a, input logic [7:0] d);
        @(negedge clk); ib_sel_a = sel_a; ib_wdata = d; ib_push = 1'b1;
        @(negedge clk); ib_push = 1'b0;
    endtask

    task automatic ibpop(input logic sel_a, input string req, input logic [7:0] exp);
        @(negedge clk); ib_sel_a = sel_a; #1 chk(req, ib_rdata, exp); ib_pop = 1'b1;
        @(negedge clk); ib_pop = 1'b0;
    endtask

    task automatic clr_stat;
        @(negedge clk); stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 drq", drq, 0); chk("R1 irq", done_irq, 0); chk("R1 err", err_flag, 0);
        chk("R1 count", xfer_left, 0); chk("R1 ready", fifo_ready, 1);
        chk("R1 rdata", host_rdata, 0);
        ib_sel_a = 1'b1; #1 chk("R1 A empty", ib_avail, 0);
    endtask

    task automatic t_word_write;
        xfer_to_bus = 1'b1;
        hwrite(2'b00, 1'b1, 1'b0, 16'hA55A);
        ibpop(1'b1, "R2 upper to A", 8'hA5);
        ibpop(1'b0, "R2 lower to B", 8'h5A);
    endtask

    task automatic t_single_lane;
        xfer_to_bus = 1'b1;
        hwrite(2'b01, 1'b1, 1'b0, 16'h3C00);
        hwrite(2'b10, 1'b1, 1'b0, 16'h00C3);
        ib_sel_a = 1'b1; #1 chk("R3 A untouched", ib_avail, 0);
        ibpop(1'b0, "R3 upper lane to B", 8'h3C);
        ibpop(1'b0, "R3 lower lane to B", 8'hC3);
        xfer_to_bus = 1'b0;
        ibpush(1'b0, 8'h22); ibpush(1'b0, 8'h33);
        hread(2'b01, 1'b1, 1'b0, rd_word); chk("R3 read B on upper", rd_word, 16'h2200);
        hread(2'b10, 1'b1, 1'b0, rd_word); chk("R3 read B on lower", rd_word, 16'h0033);
    endtask

    task automatic t_no_strobe_zero;
        xfer_to_bus = 1'b0;
        ibpush(1'b1, 8'h44); ibpush(1'b0, 8'h55);
        @(negedge clk); fifo_cs = 1'b1; {ube_n, lbe_n} = 2'b00;
        #1 chk("R6 rdata zero without strobe", host_rdata, 0);
        fifo_cs = 1'b0; {ube_n, lbe_n} = 2'b11;
        hread(2'b00, 1'b1, 1'b0, rd_word); chk("R2 word read", rd_word, 16'h4455);
    endtask

    task automatic t_burst;
        xfer_to_bus = 1'b0;
        ibpush(1'b1, 8'h11); ibpush(1'b1, 8'h12);
        ibpush(1'b0, 8'h21); ibpush(1'b0, 8'h22);
        burst_mode = 1'b1;
        @(negedge clk); #1 chk("R5 head shown without strobe", host_rdata, 16'h1121);
        hread(2'b11, 1'b0, 1'b0, rd_word);
        #1 chk("R5 one word removed", host_rdata, 16'h1222);
        hread(2'b11, 1'b0, 1'b0, rd_word);
        chk("R7 empty not ready", fifo_ready, 0);
        burst_mode = 1'b0;
    endtask

    task automatic t_ready;
        xfer_to_bus = 1'b0;
        ibpush(1'b1, 8'h01);
        @(negedge clk); chk("R7 one side only", fifo_ready, 0);
        ibpush(1'b0, 8'h02);
        @(negedge clk); chk("R7 word available", fifo_ready, 1);
        hread(2'b00, 1'b1, 1'b0, rd_word);
    endtask

    task automatic t_overflow;
        xfer_to_bus = 1'b1;
        for (int i = 0; i < 16; i++) hwrite(2'b00, 1'b1, 1'b0, {8'(i), 8'(i + 16'h80)});
        chk("R7 full not ready", fifo_ready, 0);
        chk("R11 no error yet", err_flag, 0);
        hwrite(2'b00, 1'b1, 1'b0, 16'hEEEE);
        chk("R11 overflow flagged", err_flag, 1);
        for (int i = 0; i < 16; i++) ibpop(1'b1, "R11 A data intact", 8'(i));
        for (int i = 0; i < 16; i++) ibpop(1'b0, "R11 B data intact", 8'(i + 16'h80));
        ib_sel_a = 1'b1; #1 chk("R11 extra byte dropped", ib_avail, 0);
        clr_stat(); chk("R11 cleared", err_flag, 0);
        ibpop(1'b1, "R11 pop empty", ib_rdata);
        @(negedge clk); chk("R11 underflow flagged", err_flag, 1);
        clr_stat();
    endtask

    task automatic t_dma_write;
        xfer_to_bus = 1'b1; dma_en = 1'b1; dma_wide = 1'b1;
        @(negedge clk); cnt_value = 5; cnt_load = 1'b1; @(negedge clk); cnt_load = 1'b0;
        chk("R8 loaded", xfer_left, 5); chk("R9 request up", drq, 1);
        hwrite(2'b00, 1'b0, 1'b1, 16'h0102); chk("R8 minus two", xfer_left, 3);
        hwrite(2'b00, 1'b0, 1'b1, 16'h0304);
        hwrite(2'b10, 1'b0, 1'b1, 16'h0005); chk("R8 minus one", xfer_left, 0);
        chk("R9 request down at zero", drq, 0);
        chk("R10 not before drain", done_irq, 0);
        ibpop(1'b1, "R4 dack A", 8'h01); ibpop(1'b1, "R4 dack A", 8'h03);
        ibpop(1'b0, "R4 dack B", 8'h02); ibpop(1'b0, "R4 dack B", 8'h04);
        ibpop(1'b0, "R4 dack B narrow", 8'h05);
        idle(2); chk("R10 fires after drain", done_irq, 1);
        idle(5); chk("R10 sticky", done_irq, 1);
        clr_stat(); idle(2); chk("R10 cleared", done_irq, 0);
        @(negedge clk); cnt_value = 1; cnt_load = 1'b1; @(negedge clk); cnt_load = 1'b0;
        hwrite(2'b00, 1'b0, 1'b1, 16'h0607); chk("R8 saturates", xfer_left, 0);
        ibpop(1'b1, "R8 word", 8'h06); ibpop(1'b0, "R8 word", 8'h07);
        idle(2); clr_stat();
    endtask

    task automatic t_dma_throttle;
        xfer_to_bus = 1'b1; dma_en = 1'b1; dma_wide = 1'b0;
        @(negedge clk); cnt_value = 100; cnt_load = 1'b1; @(negedge clk); cnt_load = 1'b0;
        for (int i = 0; i < 16; i++) hwrite(2'b10, 1'b0, 1'b1, 16'(i));
        chk("R8 count", xfer_left, 84); chk("R9 down when full", drq, 0);
        ibpop(1'b0, "R9 first", 8'h00);
        @(negedge clk); chk("R9 up with room", drq, 1);
        for (int i = 1; i < 16; i++) ibpop(1'b0, "R9 drain", 8'(i));
        dma_en = 1'b0;
    endtask

    task automatic t_dma_read;
        xfer_to_bus = 1'b0; dma_en = 1'b1; dma_wide = 1'b1;
        @(negedge clk); cnt_value = 2; cnt_load = 1'b1; @(negedge clk); cnt_load = 1'b0;
        chk("R9 down when empty", drq, 0);
        ibpush(1'b1, 8'h77);
        @(negedge clk); chk("R9 wide needs both", drq, 0);
        ibpush(1'b0, 8'h88);
        @(negedge clk); chk("R9 up with word", drq, 1);
        hread(2'b00, 1'b0, 1'b1, rd_word); chk("R4 dack read", rd_word, 16'h7788);
        chk("R9 down after last", drq, 0);
        idle(1); chk("R10 read done", done_irq, 1);
        clr_stat(); dma_en = 1'b0;
    endtask

    initial begin
        idle(3); rst_n = 1'b1; idle(1);
        t_reset(); t_word_write(); t_single_lane(); t_no_strobe_zero();
        t_burst(); t_ready(); t_overflow(); t_dma_write(); t_dma_throttle(); t_dma_read();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule